// File: doc/BRIEF.md
# Direct-Mapped Word Cache

This block is a cache that sits between a processor access port and a slower main-memory port. A word address is split into a tag (upper bits) and an index (lower bits). The index on its own selects one cache line, and each line holds one data word together with its stored tag, a valid bit and a dirty bit. The defaults suit a 32K-word by 12-bit memory: 15 address bits, a 9-bit index and a 6-bit tag. Two addresses that share an index therefore compete for the same line.

The `WRITE_BACK` parameter chooses the write policy. In write-through mode every processor write goes to the line and to main memory. The memory write runs in the background, and the processor waits only if it starts another access before that write has finished. In write-back mode a write changes only the line and marks it dirty. A dirty line is copied out to memory when a miss evicts it, before the new word is fetched. A write miss first allocates the line by fetching it and then overwrites the word. Hit and miss counters let the environment work out the hit ratio.

A four-state controller drives all memory traffic. IDLE accepts a request, or a flush. From IDLE: a hit goes to RESPOND; a miss on a dirty valid line (write-back only) goes to WRITEBACK; any other miss goes to REFILL. WRITEBACK moves to REFILL when memory returns ready. REFILL moves to RESPOND when memory returns ready. RESPOND returns to IDLE after one cycle.

Top module: `dmc_cache`

## Requirements
- R1: Bits [IDX_W-1:0] of the address select the line and bits [ADDR_W-1:IDX_W] form the tag. A hit needs the line to be valid and its stored tag to equal the request tag.
- R2: A read hit returns the stored word with `cpu_ready` high for exactly one cycle, one clock edge after the request is accepted. It generates no memory traffic.
- R3: A clean read miss fetches the requested address from memory, fills the line and returns the fetched word. `cpu_ready` rises LAT+2 edges after acceptance for a memory that answers in LAT edges.
- R4: Addresses that share an index evict each other, so a later access to the evicted address misses.
- R5: In write-through mode a write updates the line and also writes the same address and data to memory. Lines never become dirty.
- R6: In write-through mode, an access issued while a memory write is still pending is held in IDLE. It is accepted on the edge where that write's `mem_ready` arrives.
- R7: In write-back mode a write hit updates only the line. It sets the dirty bit, responds after one edge and leaves main memory unchanged.
- R8: In write-back mode, a miss on a valid dirty line first writes that line's word to address {stored tag, index} and then refills. The response arrives 2*LAT+3 edges after acceptance.
- R9: A write miss fetches the line first and then stores the write data into it. The response returns the written word.
- R10: Reset and a `flush` pulse in IDLE clear every valid bit. A flush discards dirty data without writing it back, and the next access to any address misses.
- R11: `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` stay stable from the start of a transfer until `mem_ready`. After reset `mem_req` is low.
- R12: Each accepted access increments exactly one of `hit_count` (hit) or `miss_count` (miss). Both counters are zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate every line; honoured in IDLE |
| cpu_req | input | 1 | Access request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Write data |
| cpu_rdata | output | DATA_W | Line word, valid while `cpu_ready` |
| cpu_ready | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | Memory transfer is a write |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, valid with `mem_ready` |
| mem_ready | input | 1 | One-cycle memory completion strobe |
| hit_count | output | CNT_W | Accepted hits since reset |
| miss_count | output | CNT_W | Accepted misses since reset |

## Verification
A request is accepted on the first rising edge that finds the controller in IDLE. Counting from that edge, `cpu_ready` is due after 1 edge for a hit, LAT+2 edges for a clean miss and 2*LAT+3 edges for a dirty miss. In write-through mode, an access issued one idle cycle after a write completes only after LAT edges. The bench counts falling edges from the moment it issues a request until it sees `cpu_ready`, and compares that count with these formulas. Read data and counters are sampled at the falling edge of the response cycle. Main memory is compared only after the background write has had LAT+2 idle cycles to finish.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_WRITEBACK = 2'd1,
        ST_REFILL    = 2'd2,
        ST_RESPOND   = 2'd3
    } dmc_state_t;
endpackage

// File: rtl/dmc_tag_store.sv
module dmc_tag_store #(
    parameter int IDX_W      = 9,
    parameter int TAG_W      = 6,
    parameter bit WRITE_BACK = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] line_idx,
    output logic [TAG_W-1:0] rd_tag,
    output logic             rd_valid,
    output logic             rd_dirty,
    input  logic             wr_en,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic             wr_dirty,
    input  logic             flush_all
);
    localparam int LINES = 1 << IDX_W;

    logic [TAG_W-1:0] tag_mem [LINES];
    logic [LINES-1:0] valid_vec;
    logic [LINES-1:0] dirty_vec;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_mem[line_idx] <= wr_tag;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || flush_all) begin
            valid_vec <= '0;
        end else if (wr_en) begin
            valid_vec[line_idx] <= 1'b1;
        end
    end

    generate
        if (WRITE_BACK) begin : g_dirty
            always_ff @(posedge clk) begin
                if (!rst_n || flush_all) begin
                    dirty_vec <= '0;
                end else if (wr_en) begin
                    dirty_vec[line_idx] <= wr_dirty;
                end
            end
        end else begin : g_clean
            assign dirty_vec = '0;
        end
    endgenerate

    assign rd_tag   = tag_mem[line_idx];
    assign rd_valid = valid_vec[line_idx];
    assign rd_dirty = dirty_vec[line_idx];

    // R10
    flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_all |=> (valid_vec == '0));
endmodule

// File: rtl/dmc_data_store.sv
module dmc_data_store #(
    parameter int IDX_W  = 9,
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic [IDX_W-1:0]  line_idx,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data
);
    localparam int LINES = 1 << IDX_W;

    logic [DATA_W-1:0] word_mem [LINES];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            word_mem[line_idx] <= wr_data;
        end
    end

    assign rd_data = word_mem[line_idx];
endmodule

// File: rtl/dmc_ctrl.sv
module dmc_ctrl
    import dmc_pkg::*;
#(
    parameter int ADDR_W     = 15,
    parameter int IDX_W      = 9,
    parameter int DATA_W     = 12,
    parameter int CNT_W      = 16,
    parameter bit WRITE_BACK = 1'b1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     flush,
    input  logic                     cpu_req,
    input  logic                     cpu_we,
    input  logic [ADDR_W-1:0]        cpu_addr,
    input  logic [DATA_W-1:0]        cpu_wdata,
    output logic [DATA_W-1:0]        cpu_rdata,
    output logic                     cpu_ready,
    output logic                     mem_req,
    output logic                     mem_we,
    output logic [ADDR_W-1:0]        mem_addr,
    output logic [DATA_W-1:0]        mem_wdata,
    input  logic [DATA_W-1:0]        mem_rdata,
    input  logic                     mem_ready,
    output logic [CNT_W-1:0]         hit_count,
    output logic [CNT_W-1:0]         miss_count,
    output logic [IDX_W-1:0]         line_idx,
    input  logic [ADDR_W-IDX_W-1:0]  rd_tag,
    input  logic                     rd_valid,
    input  logic                     rd_dirty,
    output logic                     tag_we,
    output logic [ADDR_W-IDX_W-1:0]  tag_wr_tag,
    output logic                     tag_wr_dirty,
    output logic                     flush_all,
    input  logic [DATA_W-1:0]        line_data,
    output logic                     data_we,
    output logic [DATA_W-1:0]        data_wr
);
    localparam int TAG_W = ADDR_W - IDX_W;

    dmc_state_t        state, state_nx;
    logic [ADDR_W-1:0] req_addr;
    logic              req_we;
    logic [DATA_W-1:0] req_wdata;
    logic              wt_busy;
    logic [ADDR_W-1:0] wt_addr;
    logic [DATA_W-1:0] wt_data;
    logic              lookup_hit, accept, refill_done, wt_start;
    logic [TAG_W-1:0]  cpu_tag, req_tag;

    assign cpu_tag = cpu_addr[ADDR_W-1:IDX_W];
    assign req_tag = req_addr[ADDR_W-1:IDX_W];

    always_comb begin
        line_idx    = (state == ST_IDLE) ? cpu_addr[IDX_W-1:0] : req_addr[IDX_W-1:0];
        lookup_hit  = rd_valid && (rd_tag == cpu_tag);
        accept      = (state == ST_IDLE) && cpu_req && !flush && (!wt_busy || mem_ready);
        refill_done = (state == ST_REFILL) && mem_ready;
        wt_start    = !WRITE_BACK && ((accept && lookup_hit && cpu_we) || (refill_done && req_we));
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (accept) begin
                    if (lookup_hit)                             state_nx = ST_RESPOND;
                    else if (WRITE_BACK && rd_valid && rd_dirty) state_nx = ST_WRITEBACK;
                    else                                        state_nx = ST_REFILL;
                end
            end
            ST_WRITEBACK: if (mem_ready) state_nx = ST_REFILL;
            ST_REFILL:    if (mem_ready) state_nx = ST_RESPOND;
            ST_RESPOND:   state_nx = ST_IDLE;
            default:      state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        cpu_ready    = 1'b0;
        cpu_rdata    = line_data;
        mem_req      = 1'b0;
        mem_we       = 1'b0;
        mem_addr     = '0;
        mem_wdata    = '0;
        tag_we       = 1'b0;
        tag_wr_tag   = rd_tag;
        tag_wr_dirty = 1'b0;
        flush_all    = 1'b0;
        data_we      = 1'b0;
        data_wr      = line_data;
        unique case (state)
            ST_IDLE: begin
                flush_all = flush;
                if (accept && lookup_hit && cpu_we) begin
                    data_we      = 1'b1;
                    data_wr      = cpu_wdata;
                    tag_we       = 1'b1;
                    tag_wr_tag   = cpu_tag;
                    tag_wr_dirty = WRITE_BACK;
                end
            end
            ST_WRITEBACK: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = {rd_tag, req_addr[IDX_W-1:0]};
                mem_wdata = line_data;
                if (mem_ready) begin
                    tag_we       = 1'b1;
                    tag_wr_dirty = 1'b0;
                end
            end
            ST_REFILL: begin
                mem_req  = 1'b1;
                mem_addr = req_addr;
                if (mem_ready) begin
                    data_we      = 1'b1;
                    data_wr      = req_we ? req_wdata : mem_rdata;
                    tag_we       = 1'b1;
                    tag_wr_tag   = req_tag;
                    tag_wr_dirty = req_we && WRITE_BACK;
                end
            end
            ST_RESPOND: cpu_ready = 1'b1;
            default: ;
        endcase
        if (wt_busy && (state == ST_IDLE || state == ST_RESPOND)) begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = wt_addr;
            mem_wdata = wt_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_addr   <= '0;
            req_we     <= 1'b0;
            req_wdata  <= '0;
            wt_busy    <= 1'b0;
            wt_addr    <= '0;
            wt_data    <= '0;
            hit_count  <= '0;
            miss_count <= '0;
        end else begin
            if (accept) begin
                req_addr  <= cpu_addr;
                req_we    <= cpu_we;
                req_wdata <= cpu_wdata;
                if (lookup_hit) hit_count  <= hit_count + CNT_W'(1);
                else            miss_count <= miss_count + CNT_W'(1);
            end
            if (wt_start) begin
                wt_busy <= 1'b1;
                wt_addr <= (state == ST_IDLE) ? cpu_addr  : req_addr;
                wt_data <= (state == ST_IDLE) ? cpu_wdata : req_wdata;
            end else if (wt_busy && mem_ready) begin
                wt_busy <= 1'b0;
            end
        end
    end

    // R11
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));
    // R2
    ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |=> !cpu_ready);
    // R8
    refill_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_REFILL) |-> !(rd_valid && rd_dirty));
    // R5
    wt_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ready && req_we && !WRITE_BACK) |-> (mem_req && mem_we && mem_addr == req_addr && mem_wdata == req_wdata));
    // R6
    wt_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && cpu_req && !flush && wt_busy && !mem_ready) |=> (state == ST_IDLE));
    // R12
    count_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_count != $past(hit_count)) |-> (miss_count == $past(miss_count)));
endmodule

// File: rtl/dmc_cache.sv
module dmc_cache #(
    parameter int ADDR_W     = 15,
    parameter int IDX_W      = 9,
    parameter int DATA_W     = 12,
    parameter int CNT_W      = 16,
    parameter bit WRITE_BACK = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_ready,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ready,
    output logic [CNT_W-1:0]  hit_count,
    output logic [CNT_W-1:0]  miss_count
);
    localparam int TAG_W = ADDR_W - IDX_W;

    logic [IDX_W-1:0]  line_idx;
    logic [TAG_W-1:0]  rd_tag, tag_wr_tag;
    logic              rd_valid, rd_dirty, tag_we, tag_wr_dirty, flush_all;
    logic [DATA_W-1:0] line_data, data_wr;
    logic              data_we;

    dmc_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .WRITE_BACK(WRITE_BACK)) u_tags (
        .clk(clk), .rst_n(rst_n), .line_idx(line_idx),
        .rd_tag(rd_tag), .rd_valid(rd_valid), .rd_dirty(rd_dirty),
        .wr_en(tag_we), .wr_tag(tag_wr_tag), .wr_dirty(tag_wr_dirty),
        .flush_all(flush_all)
    );

    dmc_data_store #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_data (
        .clk(clk), .line_idx(line_idx), .rd_data(line_data),
        .wr_en(data_we), .wr_data(data_wr)
    );

    dmc_ctrl #(
        .ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W),
        .CNT_W(CNT_W), .WRITE_BACK(WRITE_BACK)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
        .hit_count(hit_count), .miss_count(miss_count),
        .line_idx(line_idx), .rd_tag(rd_tag), .rd_valid(rd_valid), .rd_dirty(rd_dirty),
        .tag_we(tag_we), .tag_wr_tag(tag_wr_tag), .tag_wr_dirty(tag_wr_dirty),
        .flush_all(flush_all), .line_data(line_data),
        .data_we(data_we), .data_wr(data_wr)
    );
endmodule

// File: tb/dmc_cache_test.sv
module dmc_cache_env #(
    parameter bit WB  = 1'b1,
    parameter int LAT = 3
) (
    input  logic clk,
    input  logic rst_n,
    output logic done,
    output int   n_checks,
    output int   n_fails
);
    localparam int AW = 5, IW = 3, DW = 12, CW = 16;
    localparam int MEM_N = 1 << AW, LINES = 1 << IW;

    logic          flush, cpu_req, cpu_we, cpu_ready, mem_req, mem_we, mem_ready;
    logic [AW-1:0] cpu_addr, mem_addr;
    logic [DW-1:0] cpu_wdata, cpu_rdata, mem_wdata, mem_rdata;
    logic [CW-1:0] hit_count, miss_count;

    dmc_cache #(.ADDR_W(AW), .IDX_W(IW), .DATA_W(DW), .CNT_W(CW), .WRITE_BACK(WB)) uut (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ready(mem_ready),
        .hit_count(hit_count), .miss_count(miss_count)
    );

    // main memory model: answers each transfer after LAT edges
    logic [DW-1:0] mem [MEM_N];
    int            lat_cnt;

    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ready <= 1'b0;
            lat_cnt   <= 0;
            mem_rdata <= '0;
        end else if (mem_req && !mem_ready) begin
            if (lat_cnt == LAT - 1) begin
                mem_ready <= 1'b1;
                lat_cnt   <= 0;
                if (mem_we) mem[mem_addr] <= mem_wdata;
                else        mem_rdata     <= mem[mem_addr];
            end else begin
                lat_cnt <= lat_cnt + 1;
            end
        end else begin
            mem_ready <= 1'b0;
        end
    end

    // reference state
    int exp_mem [MEM_N];
    int ctag [LINES], cdata [LINES];
    bit cval [LINES], cdirty [LINES];
    int exp_hits, exp_misses;

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s [%s] %s actual=%0d expected=%0d", tag, WB ? "wb" : "wt", what, act, exp);
        end
    endtask

    function automatic void predict(input bit we, input int addr, input int wdata,
                                    output int rd, output int lat, output string tag);
        int idx = addr % LINES;
        int tg  = addr / LINES;
        if (cval[idx] && ctag[idx] == tg) begin
            exp_hits++;
            lat = 1;
            tag = we ? (WB ? "R7" : "R5") : "R2";
            if (we) begin
                cdata[idx] = wdata;
                if (WB) cdirty[idx] = 1'b1;
                else    exp_mem[addr] = wdata;
            end
        end else begin
            exp_misses++;
            if (WB && cval[idx] && cdirty[idx]) begin
                exp_mem[ctag[idx] * LINES + idx] = cdata[idx];
                lat = 2 * LAT + 3;
                tag = "R8";
            end else begin
                lat = LAT + 2;
                tag = we ? "R9" : "R3";
            end
            ctag[idx]   = tg;
            cval[idx]   = 1'b1;
            cdata[idx]  = we ? wdata : exp_mem[addr];
            cdirty[idx] = we && WB;
            if (we && !WB) exp_mem[addr] = wdata;
        end
        rd = cdata[idx];
    endfunction

    task automatic access(input bit we, input int addr, input int wdata, input bit nogap,
                          output int rd, output int lat);
        cpu_we    = we;
        cpu_addr  = AW'(addr);
        cpu_wdata = DW'(wdata);
        cpu_req   = 1'b1;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (!cpu_ready && lat < 200);
        rd      = int'(cpu_rdata);
        cpu_req = 1'b0;
        cpu_we  = 1'b0;
        @(negedge clk);
        if (we && !WB && !nogap) repeat (LAT + 2) @(negedge clk);
    endtask

    task automatic do_acc(input bit we, input int addr, input int wdata, input bit nogap,
                          input string tag_ovr, input int lat_ovr);
        int rd, lat, e_rd, e_lat;
        string tag;
        predict(we, addr, wdata, e_rd, e_lat, tag);
        if (lat_ovr > 0) e_lat = lat_ovr;
        if (tag_ovr != "") tag = tag_ovr;
        access(we, addr, wdata, nogap, rd, lat);
        chk(tag, $sformatf("rdata addr=%0d", addr), rd, e_rd);
        chk(tag, $sformatf("latency addr=%0d", addr), lat, e_lat);
    endtask

    task automatic check_mem(input string tag);
        for (int i = 0; i < MEM_N; i++) begin
            chk(tag, $sformatf("memory word %0d", i), int'(mem[i]), exp_mem[i]);
        end
    endtask

    task automatic check_counts(input string tag);
        chk(tag, "hit_count", int'(hit_count), exp_hits);
        chk(tag, "miss_count", int'(miss_count), exp_misses);
    endtask

    initial begin
        done = 1'b0; n_checks = 0; n_fails = 0;
        flush = 1'b0; cpu_req = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0;
        exp_hits = 0; exp_misses = 0;
        for (int i = 0; i < MEM_N; i++) begin
            mem[i]     = DW'(i * 37 + 5);
            exp_mem[i] = (i * 37 + 5) % 4096;
        end
        for (int i = 0; i < LINES; i++) begin
            cval[i] = 1'b0; cdirty[i] = 1'b0; ctag[i] = 0; cdata[i] = 0;
        end
        wait (rst_n === 1'b1);
        @(negedge clk);
        // R10 R11 R12 reset state
        chk("R10", "cpu_ready after reset", int'(cpu_ready), 0);
        chk("R11", "mem_req after reset", int'(mem_req), 0);
        check_counts("R12");
        // R3: every address once; R1: index is the low bits
        for (int a = 0; a < MEM_N; a++) do_acc(1'b0, a, 0, 1'b0, "", 0);
        // R2: last tag loaded in each line hits
        for (int a = 24; a < 32; a++) do_acc(1'b0, a, 0, 1'b0, "", 0);
        check_counts("R12");
        // R5 / R7: write hits
        for (int a = 24; a < 32; a++) do_acc(1'b1, a, (a * 101 + 7) % 4096, 1'b0, "", 0);
        check_mem(WB ? "R7" : "R5");
        // R4 / R8: conflicting index evicts (dirty victims written in write-back)
        for (int a = 0; a < 8; a++) do_acc(1'b0, a, 0, 1'b0, a == 0 ? "R4" : "", 0);
        check_mem(WB ? "R8" : "R5");
        // R9: write misses allocate then merge, then read back as hits
        for (int a = 8; a < 16; a++) do_acc(1'b1, a, (a * 13 + 3) % 4096, 1'b0, "", 0);
        for (int a = 8; a < 16; a++) do_acc(1'b0, a, 0, 1'b0, "R9", 0);
        // R6: access right behind a write (stall only in write-through)
        do_acc(1'b1, 8, 777, 1'b1, "R6", 0);
        do_acc(1'b0, 9, 0, 1'b0, "R6", WB ? 1 : LAT);
        repeat (LAT + 2) @(negedge clk);
        check_counts("R12");
        // R10: flush discards all lines, dirty data included
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        @(negedge clk);
        for (int i = 0; i < LINES; i++) begin
            cval[i] = 1'b0; cdirty[i] = 1'b0;
        end
        chk("R10", "mem_req after flush", int'(mem_req), 0);
        do_acc(1'b0, 8, 0, 1'b0, "R10", 0);
        do_acc(1'b0, 3, 0, 1'b0, "R10", 0);
        check_mem("R10");
        check_counts("R12");
        done = 1'b1;
    end
endmodule

module dmc_cache_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic done_wb, done_wt;
    int   chk_wb, chk_wt, fail_wb, fail_wt;
    int   cyc;
    int   wd_fail;

    always #10 clk = ~clk;

    dmc_cache_env #(.WB(1'b1), .LAT(3)) u_env_wb (
        .clk(clk), .rst_n(rst_n), .done(done_wb), .n_checks(chk_wb), .n_fails(fail_wb));
    dmc_cache_env #(.WB(1'b0), .LAT(3)) u_env_wt (
        .clk(clk), .rst_n(rst_n), .done(done_wt), .n_checks(chk_wt), .n_fails(fail_wt));

    initial begin
        wd_fail = 0;
        cyc = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        while (!(done_wb === 1'b1 && done_wt === 1'b1) && cyc < 20000) begin
            @(negedge clk);
            cyc++;
        end
        if (!(done_wb === 1'b1 && done_wt === 1'b1)) begin
            wd_fail = 1;
            $display("FAIL watchdog: run did not complete, actual=%0d cycles expected<20000", cyc);
        end
        $display("TB_RESULT checks=%0d failures=%0d", chk_wb + chk_wt + wd_fail, fail_wb + fail_wt + wd_fail);
        $finish;
    end
endmodule